// File: doc/BRIEF.md
# Edge Capture Timer

This block timestamps signal transitions on two input pins. A 12-bit counter advances once per microsecond, from a clock enable that divides the system clock. Each pin has its own synchroniser and edge detector. A rising edge and a falling edge on a pin are separate events. That gives four events in all, and each one loads an 8-bit window of the counter into its own capture register. A configuration field picks which window is taken, which trades resolution against range: steps of 1, 2, 4, 8 or 16 counts.

Every event also sets a sticky status flag. Reading an event's capture register clears that event's flag. A global hold mode keeps the first timestamp of each event until software reads it. The two events of pin A form one interrupt request, and the two events of pin B form the other. Each event has its own enable, and an external master enable gates both requests. Software reaches the block through a byte-wide register bus with an address, a read strobe and a write strobe.

Top module: `edge_capture_timer`

## Requirements
- R1: The time counter is 12 bits wide. It advances by one on every sixth clock after reset and wraps from 0xFFF to 0x000. It is 0 after reset.
- R2: Each pin is sampled through two flip-flops before edge detection. A pin change applied before clock edge k is captured at edge k+2, using the counter value held during the cycle before that edge.
- R3: The capture registers are read-only, at base+0 (pin A rising), base+1 (pin A falling), base+2 (pin B rising) and base+3 (pin B falling), with base 0x40. A bus write to these addresses leaves their contents unchanged.
- R4: The configuration register is at base+4 and can be read and written. Bit 7 is hold mode, bits 6:4 are the window select and bits 3:0 are the interrupt enables. It resets to 0x00.
- R5: Window codes 0, 1, 2, 3 and 4 capture counter bits 7:0, 8:1, 9:2, 10:3 and 11:4.
- R6: Window codes 5, 6 and 7 capture counter bits 11:4, the same as code 4.
- R7: The status register is at base+5. Bit 0 is pin A rising, bit 1 pin A falling, bit 2 pin B rising and bit 3 pin B falling. Bits 7:4 read as 0. A flag sets on its event and stays set.
- R8: Reading a capture register clears only that register's flag. Reading the status register clears nothing.
- R9: With hold mode at 0, each event overwrites its capture register with the latest timestamp.
- R10: With hold mode at 1, an event whose flag is already set is ignored. The first timestamp stays until the register is read, and the next event after the read is captured.
- R11: When an event and a read of its own register fall in the same cycle, the read returns the old value, the new timestamp is stored and the flag stays set.
- R12: irq_a is high exactly when the master enable is high and (flag bit 0 AND enable bit 0) OR (flag bit 1 AND enable bit 1). irq_b follows the same rule with bits 2 and 3.
- R13: After reset every register reads 0 and both interrupt requests are low. Reads of addresses outside base+0 to base+5 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; clears the flag of the capture register addressed |
| bus_rdata | output | 8 | Read data for the address presented |
| cap_pin_a | input | 1 | Asynchronous capture input A |
| cap_pin_b | input | 1 | Asynchronous capture input B |
| cap_irq_master_en | input | 1 | External master enable for both interrupt requests |
| irq_a | output | 1 | Interrupt request for the pin A events |
| irq_b | output | 1 | Interrupt request for the pin B events |

## Verification
A wrong divider or counter state only becomes visible through a later timestamp, so the bench computes every expected capture from the cycle count since reset. A single wrong count then shows up as soon as the affected register is read. A run past the counter wrap also exposes a counter that saturates or sticks. A flag that is set wrongly or fails to clear shows up in the next status read and, when its enable is set, at once on the interrupt pins. Hold-mode and collision errors show up as a stale or lost timestamp on the following read of that register.

// File: rtl/ecap_pkg.sv
`timescale 1ns/1ps
package ecap_pkg;

    localparam int CNT_W     = 12;
    localparam int STAMP_W   = 8;
    localparam int NUM_PINS  = 2;
    localparam int NUM_EV    = 2 * NUM_PINS;
    localparam int MAX_SHIFT = CNT_W - STAMP_W;

    // Event slots; order is fixed by the status and enable bit layout
    typedef enum logic [1:0] {
        EV_A_RISE = 2'd0,
        EV_A_FALL = 2'd1,
        EV_B_RISE = 2'd2,
        EV_B_FALL = 2'd3
    } ev_e;

    // Register offsets from the block base address
    localparam int OFS_CFG  = 4;
    localparam int OFS_STAT = 5;

    typedef struct packed {
        logic               first_hold;
        logic [2:0]         win_sel;
        logic [NUM_EV-1:0]  irq_en;
    } cfg_t;

    typedef struct packed {
        logic fall;
        logic rise;
    } pin_ev_t;

    function automatic logic [2:0] win_shift(input logic [2:0] code);
        return (code > 3'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : code;
    endfunction

    function automatic logic [STAMP_W-1:0] win_slice(input logic [CNT_W-1:0] cnt,
                                                     input logic [2:0] code);
        logic [CNT_W-1:0] shifted;
        shifted = cnt >> win_shift(code);
        return shifted[STAMP_W-1:0];
    endfunction

endpackage

// File: rtl/ecap_timebase.sv
`timescale 1ns/1ps
module ecap_timebase
    import ecap_pkg::*;
#(
    parameter int TICK_DIV = 6
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick = (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == '1) |=> (cnt_q == '0));

    // R1
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

endmodule

// File: rtl/ecap_pin_sync.sv
`timescale 1ns/1ps
module ecap_pin_sync
    import ecap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pin_i,
    output pin_ev_t ev_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        ev_o.rise = sync_q & ~prev_q;
        ev_o.fall = ~sync_q & prev_q;
    end

    // R2
    rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        ev_o.rise |-> $past(pin_i, 2));

    // R2
    fall_src_chk: assert property (@(posedge clk) disable iff (rst)
        ev_o.fall |-> !$past(pin_i, 2));

endmodule

// File: rtl/ecap_channel.sv
`timescale 1ns/1ps
module ecap_channel
    import ecap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_i,
    input  logic               hold_i,
    input  logic               rd_clr_i,
    input  logic [STAMP_W-1:0] stamp_i,
    output logic [STAMP_W-1:0] data_o,
    output logic               flag_o
);
    logic [STAMP_W-1:0] data_q;
    logic               flag_q;
    logic               blocked;
    logic               load;

    // hold mode locks the slot while an unread capture is present
    assign blocked = hold_i & flag_q & ~rd_clr_i;
    assign load    = ev_i & ~blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= stamp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (ev_i) begin
            flag_q <= 1'b1;
        end else if (rd_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign data_o = data_q;
    assign flag_o = flag_q;

    // R7
    flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(ev_i));

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && !ev_i) |=> !flag_q);

    // R10
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_i && flag_q && !rd_clr_i) |=> $stable(data_q));

    // R11
    collide_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && ev_i) |=> flag_q);

endmodule

// File: rtl/edge_capture_timer.sv
`timescale 1ns/1ps
module edge_capture_timer
    import ecap_pkg::*;
#(
    parameter int TICK_DIV  = 6,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [STAMP_W-1:0] bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [STAMP_W-1:0] bus_rdata,
    input  logic               cap_pin_a,
    input  logic               cap_pin_b,
    input  logic               cap_irq_master_en,
    output logic               irq_a,
    output logic               irq_b
);
    localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(BASE_ADDR + OFS_CFG);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(BASE_ADDR + OFS_STAT);
    localparam int STAT_PAD = STAMP_W - NUM_EV;

    logic [CNT_W-1:0]   cnt;
    logic [STAMP_W-1:0] stamp;
    cfg_t               cfg_q;
    logic [NUM_PINS-1:0] pins;
    pin_ev_t            pin_ev [NUM_PINS];
    logic [NUM_EV-1:0]  ev;
    logic [NUM_EV-1:0]  rd_clr;
    logic [NUM_EV-1:0]  flags;
    logic [STAMP_W-1:0] chan_data [NUM_EV];
    logic [NUM_EV-1:0]  pend;

    ecap_timebase #(.TICK_DIV(TICK_DIV)) u_timebase (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt)
    );

    assign stamp = win_slice(cnt, cfg_q.win_sel);
    assign pins  = {cap_pin_b, cap_pin_a};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (bus_wr && bus_addr == CFG_ADDR) begin
            cfg_q <= cfg_t'(bus_wdata);
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        ecap_pin_sync u_sync (
            .clk   (clk),
            .rst   (rst),
            .pin_i (pins[p]),
            .ev_o  (pin_ev[p])
        );
        assign ev[2*p]     = pin_ev[p].rise;
        assign ev[2*p + 1] = pin_ev[p].fall;
    end

    for (genvar e = 0; e < NUM_EV; e++) begin : g_chan
        assign rd_clr[e] = bus_rd && (bus_addr == ADDR_W'(BASE_ADDR + e));
        ecap_channel u_chan (
            .clk      (clk),
            .rst      (rst),
            .ev_i     (ev[e]),
            .hold_i   (cfg_q.first_hold),
            .rd_clr_i (rd_clr[e]),
            .stamp_i  (stamp),
            .data_o   (chan_data[e]),
            .flag_o   (flags[e])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            if (bus_addr == ADDR_W'(BASE_ADDR + i)) begin
                bus_rdata = chan_data[i];
            end
        end
        if (bus_addr == CFG_ADDR) begin
            bus_rdata = cfg_q;
        end
        if (bus_addr == STAT_ADDR) begin
            bus_rdata = {{STAT_PAD{1'b0}}, flags};
        end
    end

    assign pend  = flags & cfg_q.irq_en;
    assign irq_a = cap_irq_master_en & (pend[EV_A_RISE] | pend[EV_A_FALL]);
    assign irq_b = cap_irq_master_en & (pend[EV_B_RISE] | pend[EV_B_FALL]);

endmodule

// File: tb/tb_edge_capture_timer.sv
`timescale 1ns/1ps
module tb_edge_capture_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       cap_pin_a = 1'b0;
    logic       cap_pin_b = 1'b0;
    logic       cap_irq_master_en = 1'b0;
    logic       irq_a;
    logic       irq_b;

    always #2 clk = ~clk;

    edge_capture_timer dut (
        .clk               (clk),
        .rst               (rst),
        .bus_addr          (bus_addr),
        .bus_wdata         (bus_wdata),
        .bus_wr            (bus_wr),
        .bus_rd            (bus_rd),
        .bus_rdata         (bus_rdata),
        .cap_pin_a         (cap_pin_a),
        .cap_pin_b         (cap_pin_b),
        .cap_irq_master_en (cap_irq_master_en),
        .irq_a             (irq_a),
        .irq_b             (irq_b)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // reference model of the register state
    logic [7:0] m_data [4];
    logic [3:0] m_flag = 4'h0;
    logic       m_hold = 1'b0;
    logic [2:0] m_win = 3'd0;
    logic [3:0] m_en = 4'h0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    // monitor: compares each read the driver announced
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd) begin
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected read addr=%02h actual=%02h expected=none", bus_addr, bus_rdata);
                end else begin
                    rd_item_t it;
                    it = sb_q.pop_front();
                    if (bus_rdata !== it.exp || bus_addr !== it.addr) begin
                        errors++;
                        $display("FAIL %s addr=%02h actual=%02h expected=%02h", it.tag, it.addr, bus_rdata, it.exp);
                    end
                end
            end
        end
    end

    function automatic logic [7:0] stamp_at(input int c);
        int cnt;
        int sh;
        cnt = ((c + 2) / 6) % 4096;
        sh  = (m_win > 3'd4) ? 4 : int'(m_win);
        return 8'((cnt >> sh) & 255);
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic set_cfg(input logic h, input logic [2:0] w, input logic [3:0] en);
        bus_write(8'h44, {h, w, en});
        m_hold = h;
        m_win  = w;
        m_en   = en;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        it.addr = a;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
        if (a >= 8'h40 && a <= 8'h43) m_flag[a - 8'h40] = 1'b0;
    endtask

    task automatic read_data(input int ev, input string tag);
        bus_read(8'(8'h40 + ev), m_data[ev], tag);
    endtask

    task automatic read_stat(input string tag);
        bus_read(8'h45, {4'h0, m_flag}, tag);
    endtask

    task automatic drive_edge(input int p, input logic v, output int ev, output logic [7:0] ts);
        @(negedge clk);
        if (p == 0) cap_pin_a = v;
        else        cap_pin_b = v;
        ts = stamp_at(cyc);
        ev = 2 * p + (v ? 0 : 1);
    endtask

    task automatic apply_capture(input int ev, input logic [7:0] ts);
        if (!m_hold || !m_flag[ev]) m_data[ev] = ts;
        m_flag[ev] = 1'b1;
    endtask

    task automatic capture(input int p, input logic v);
        int ev;
        logic [7:0] ts;
        drive_edge(p, v, ev, ts);
        repeat (3) @(negedge clk);
        apply_capture(ev, ts);
    endtask

    task automatic check_irq(input logic ea, input logic eb, input string tag);
        @(negedge clk);
        #1;
        checks++;
        if (irq_a !== ea || irq_b !== eb) begin
            errors++;
            $display("FAIL %s irq actual=%b%b expected=%b%b", tag, irq_a, irq_b, ea, eb);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_data[i] = 8'h00;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        check_irq(1'b0, 1'b0, "R13 reset irq");
        bus_read(8'h44, 8'h00, "R13 reset cfg");
        read_stat("R13 reset status");
        read_data(0, "R13 reset data");
        bus_read(8'h46, 8'h00, "R13 unmapped above");
        bus_read(8'h3F, 8'h00, "R13 unmapped below");

        // R2 R7 R8 basic capture and flag clearing
        idle(50);
        capture(0, 1'b1);
        read_stat("R7 A rise flag");
        read_stat("R8 status read keeps flags");
        read_data(0, "R2 A rise stamp");
        read_stat("R8 flag cleared by data read");

        // R7 event ordering across all four slots
        idle(20);
        capture(0, 1'b0);
        idle(13);
        capture(1, 1'b1);
        idle(17);
        capture(1, 1'b0);
        read_stat("R7 three flags");
        read_data(1, "R7 A fall stamp");
        read_data(2, "R7 B rise stamp");
        read_data(3, "R7 B fall stamp");
        read_stat("R8 all cleared");

        // R9 overwrite with hold off
        idle(30);
        capture(1, 1'b1);
        idle(40);
        capture(1, 1'b0);
        idle(40);
        capture(1, 1'b1);
        read_data(2, "R9 latest B rise");
        read_data(3, "R9 B fall");

        // R3 writes to capture registers are ignored
        bus_write(8'h42, 8'h5A);
        bus_write(8'h40, 8'hA5);
        read_data(2, "R3 write ignored B rise");
        read_data(0, "R3 write ignored A rise");

        // R4 configuration read back
        bus_write(8'h44, 8'hA5);
        bus_read(8'h44, 8'hA5, "R4 cfg readback");
        set_cfg(1'b0, 3'd0, 4'h0);
        bus_read(8'h44, 8'h00, "R4 cfg cleared");

        // R5 R6 window select, counter well above 8 bits
        idle(3000);
        for (int w = 0; w < 8; w++) begin
            set_cfg(1'b0, 3'(w), 4'h0);
            idle(97);
            capture(0, 1'b1);
            read_data(0, (w > 4) ? "R6 reserved window" : "R5 window");
            capture(0, 1'b0);
            read_data(1, (w > 4) ? "R6 reserved window fall" : "R5 window fall");
        end

        // R10 first-edge hold
        set_cfg(1'b1, 3'd0, 4'h0);
        idle(10);
        capture(0, 1'b1);
        idle(40);
        capture(0, 1'b0);
        idle(40);
        capture(0, 1'b1);
        read_stat("R10 flags under hold");
        read_data(0, "R10 first stamp held");
        read_data(1, "R10 A fall");
        idle(40);
        capture(0, 1'b0);
        idle(40);
        capture(0, 1'b1);
        read_data(0, "R10 next edge after read");

        // R11 capture and read in the same cycle
        idle(40);
        capture(0, 1'b0);
        idle(40);
        capture(0, 1'b1);
        idle(40);
        capture(0, 1'b0);
        idle(40);
        begin
            int ev;
            logic [7:0] ts;
            drive_edge(0, 1'b1, ev, ts);
            @(negedge clk);
            read_data(0, "R11 collision returns old");
            apply_capture(ev, ts);
        end
        idle(4);
        read_stat("R11 flag stays set");
        read_data(0, "R11 new stamp stored");
        read_data(1, "R11 A fall");
        set_cfg(1'b0, 3'd0, 4'h0);

        // R12 interrupt requests
        set_cfg(1'b0, 3'd0, 4'b0101);
        capture(0, 1'b0);
        read_data(1, "R12 clear A fall");
        capture(0, 1'b1);
        check_irq(1'b0, 1'b0, "R12 master low");
        cap_irq_master_en = 1'b1;
        check_irq(1'b1, 1'b0, "R12 A rise enabled");
        capture(0, 1'b0);
        read_data(0, "R12 clear A rise");
        check_irq(1'b0, 1'b0, "R12 A fall not enabled");
        capture(1, 1'b0);
        check_irq(1'b0, 1'b0, "R12 B fall not enabled");
        capture(1, 1'b1);
        check_irq(1'b0, 1'b1, "R12 B rise enabled");
        cap_irq_master_en = 1'b0;
        check_irq(1'b0, 1'b0, "R12 master gates");
        read_data(1, "R12 A fall");
        read_data(2, "R12 B rise");
        read_data(3, "R12 B fall");

        // R1 counter wrap past 0xFFF
        while (cyc < 4096 * 6 + 300) @(negedge clk);
        set_cfg(1'b0, 3'd0, 4'h0);
        capture(0, 1'b1);
        read_data(0, "R1 stamp after wrap");
        set_cfg(1'b0, 3'd4, 4'h0);
        capture(0, 1'b0);
        read_data(1, "R1 high window after wrap");

        idle(4);
        done = 1'b1;
    end

    initial begin
        while (!done) begin
            if (cyc > 150000) break;
            @(negedge clk);
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=complete");
        end
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard R13 actual=%0d pending expected=0", sb_q.size());
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule